// File: doc/BRIEF.md
# Dual Trigger Event Capture with Timestamp

This block watches two asynchronous trigger lines. Each line is brought into the clock domain through a two-flop synchronizer. Any change of the synchronized level, rising or falling, counts as an event. For each line the block reports the live level and keeps a sticky pending flag.

Every event also records the value of a free-running timestamp counter. The same counter is driven out on `ts_now_o`, so the logic that stamps video frames can use one time base and events can be matched to frames. Software reads a single status word in which the level and pending bits sit at fixed positions, and it reads the last captured timestamp through a small register port.

In event-buffered mode every event also pushes a record, made of a status byte and a timestamp, into a small FIFO. Software drains that FIFO through the same port. In raw mode only the level bits are of interest, but the status word still carries every bit. The register port has a 2-bit address and a write strobe. Read data is registered and follows the address one clock later.

Top module: `trig_event_capture`

## Requirements
- R1: After reset the status word, the last-timestamp register and both FIFO registers read zero, provided both triggers are low.
- R2: Status bit 5 shows the synchronized level of trigger 0 and bit 6 shows that of trigger 1. A change on a trigger input is visible at the read port within four clock cycles.
- R3: Any edge of a synchronized trigger, rising or falling, sets that trigger's pending bit, which is bit 1 for trigger 0 and bit 2 for trigger 1. The bit then stays set.
- R4: A write to address 0 clears each pending bit whose position carries a one in the write data. Bits written as zero are untouched. An event in the same cycle as a clear leaves the bit set.
- R5: Status bits 0, 3, 4, 7 and 9 and above always read zero. Writes to them, and to the level bits, have no effect.
- R6: `ts_now_o` starts at zero after reset and increases by one every clock cycle.
- R7: Address 1 returns the value `ts_now_o` held in the cycle before the clock edge at which the event's pending bit is set.
- R8: In buffered mode each event pushes one record, and edges on both triggers in the same cycle give a single record.
  - The record's status byte has bits 1 and 2 marking which triggers fired and bits 5 and 6 holding the new levels.
  - Address 2 returns bit 31 = FIFO not empty, bits 18:16 = entry count and bits 7:0 = the head status byte.
  - Address 3 returns the head timestamp. Both addresses read zero when the FIFO is empty.
  - Any write to address 2 pops the head. A pop on an empty FIFO has no effect.
- R9: In raw mode events push nothing into the FIFO, but they still update the pending bits and the last timestamp.
- R10: An event arriving while the FIFO holds four records is dropped, and the stored records are kept. The drop sets the sticky overflow bit, status bit 8, which a write to address 0 with bit 8 set clears.
- R11: Writes to addresses 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the frame timestamp logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 2 | Asynchronous trigger lines |
| buf_mode_i | input | 1 | 1 = event-buffered mode, 0 = raw mode |
| ts_now_o | output | 32 | Free-running timestamp |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data for `reg_addr_i` |

## Verification
The assertions check on every cycle that:
- a synchronized edge sets its pending bit on the next cycle;
- a pending bit falls only after a matching write-one-to-clear;
- the timestamp advances by one each cycle;
- the captured timestamp equals the counter value one cycle earlier;
- the FIFO count stays within its depth;
- the FIFO never grows in raw mode;
- overflow rises only when the FIFO is full.

Only the bench's scenarios can show the exact layout of each register word and the order of records leaving the FIFO. The same holds for the precedence of an event over a clear in the same cycle, and for the rule that ignored writes leave state untouched.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  // Fixed status-word layout: software decodes these positions.
  localparam int PEND_LSB = 1;
  localparam int LVL_LSB  = 5;
  localparam int OVF_BIT  = 8;
  localparam int STAT_W   = 8;
  // Head-word layout
  localparam int HEAD_VALID_BIT = 31;
  localparam int HEAD_CNT_LSB   = 16;

  typedef enum logic [1:0] {
    A_STATUS    = 2'd0,
    A_LAST_TS   = 2'd1,
    A_FIFO_HEAD = 2'd2,
    A_FIFO_TS   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign edge_o  = sync_q ^ hist_q;
endmodule

// File: rtl/trig_ts_counter.sv
module trig_ts_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_d;
  end

  assign ts_o = cnt_q;

  // R6: one step per enabled cycle
  a_r6_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_i |=> ts_o == $past(ts_o) + TS_W'(1));
endmodule

// File: rtl/trig_evt_fifo.sv
module trig_evt_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;

  always_comb begin
    wr_ptr_d = do_push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (slot_we) mem_q[e] <= data_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  // R10: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));
  // R8: an accepted push without a pop grows the count by one
  a_r8_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_o && !pop_i) |=> count_o == $past(count_o) + CNT_W'(1));
  // R8: popping an empty queue leaves it empty
  a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/trig_event_capture.sv
module trig_event_capture
  import trig_cap_pkg::*;
#(
  parameter int NUM_TRIG   = 2,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 32,
  localparam int REC_W     = STAT_W + TS_W,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                buf_mode_i,
  output logic [TS_W-1:0]     ts_now_o,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o
);
  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  logic [NUM_TRIG-1:0] lvl, edg, clr_pend, pend_q, pend_d;
  logic                ovf_q, ovf_d, any_evt, wr_status;
  logic [TS_W-1:0]     last_ts_q;
  logic [STAT_W-1:0]   rec_stat, head_stat;
  logic [TS_W-1:0]     head_ts;
  logic [REC_W-1:0]    fifo_head;
  logic [CNT_W-1:0]    fifo_cnt;
  logic                fifo_full, fifo_empty, fifo_drop, fifo_push, fifo_pop;
  logic [DATA_W-1:0]   status_word, head_word, head_ts_word, rdata_d, rdata_q;
  logic                wdata_unused;

  assign wdata_unused = ^reg_wdata_i;

  trig_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cnt_en_i (1'b1),
    .ts_o     (ts_now_o)
  );

  assign wr_status = reg_wr_i && (reg_addr_i == A_STATUS);

  for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_trig
    trig_sync_edge u_sync (
      .clk     (clk),
      .rst_n   (rst_ni),
      .async_i (trig_i[gi]),
      .level_o (lvl[gi]),
      .edge_o  (edg[gi])
    );
    assign clr_pend[gi] = wr_status && reg_wdata_i[PEND_LSB + gi];

    // R3: a synchronized edge marks the trigger pending
    a_r3_edge_sets_pend: assert property (@(posedge clk) disable iff (!rst_ni)
      edg[gi] |=> pend_q[gi]);
    // R4: a pending bit only drops after a matching clear write
    a_r4_clear_by_write: assert property (@(posedge clk) disable iff (!rst_ni)
      $fell(pend_q[gi]) |-> $past(reg_wr_i && reg_addr_i == A_STATUS
                                  && reg_wdata_i[PEND_LSB + gi]));
  end

  assign any_evt = |edg;

  // Pending, overflow and last-timestamp next state (event wins over clear)
  always_comb begin
    pend_d = (pend_q & ~clr_pend) | edg;
    ovf_d  = (ovf_q & ~(wr_status && reg_wdata_i[OVF_BIT])) | fifo_drop;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      last_ts_q <= '0;
    else if (any_evt) last_ts_q <= ts_now_o;
  end

  // Event record and status word
  always_comb begin
    rec_stat    = '0;
    status_word = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      rec_stat[PEND_LSB + i]    = edg[i];
      rec_stat[LVL_LSB + i]     = lvl[i];
      status_word[PEND_LSB + i] = pend_q[i];
      status_word[LVL_LSB + i]  = lvl[i];
    end
    status_word[OVF_BIT] = ovf_q;
  end

  assign fifo_push = any_evt && buf_mode_i;
  assign fifo_pop  = reg_wr_i && (reg_addr_i == A_FIFO_HEAD);

  trig_evt_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_ni),
    .push_i  (fifo_push),
    .data_i  ({rec_stat, ts_now_o}),
    .pop_i   (fifo_pop),
    .head_o  (fifo_head),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  assign head_stat = fifo_head[REC_W-1 -: STAT_W];
  assign head_ts   = fifo_head[TS_W-1:0];

  always_comb begin
    head_word    = '0;
    head_ts_word = '0;
    if (!fifo_empty) begin
      head_word[HEAD_VALID_BIT]              = 1'b1;
      head_word[HEAD_CNT_LSB +: CNT_W]       = fifo_cnt;
      head_word[STAT_W-1:0]                  = head_stat;
      head_ts_word                           = DATA_W'(head_ts);
    end
  end

  // Read mux, registered
  always_comb begin
    unique case (reg_addr_i)
      A_STATUS:    rdata_d = status_word;
      A_LAST_TS:   rdata_d = DATA_W'(last_ts_q);
      A_FIFO_HEAD: rdata_d = head_word;
      default:     rdata_d = head_ts_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;

  // R7: captured time equals the counter one cycle earlier
  a_r7_ts_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    any_evt |=> last_ts_q == $past(ts_now_o));
  // R9: in raw mode the queue never grows
  a_r9_raw_no_push: assert property (@(posedge clk) disable iff (!rst_ni)
    (fifo_cnt > $past(fifo_cnt)) |-> $past(buf_mode_i));
  // R10: overflow rises only when a push met a full queue
  a_r10_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(fifo_full));
endmodule

// File: tb/trig_event_capture_test.sv
module trig_event_capture_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  trig;
  logic        buf_mode;
  logic [31:0] ts_now;
  logic [1:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Bench model
  logic [1:0]  m_lvl, m_pend;
  logic        m_ovf;
  logic [31:0] m_last;
  logic [7:0]  q_stat[$];
  logic [31:0] q_ts[$];

  always #10 clk = ~clk;

  trig_event_capture uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .buf_mode_i(buf_mode),
    .ts_now_o(ts_now), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  function automatic logic [31:0] exp_status();
    return (32'(m_pend) << 1) | (32'(m_lvl) << 5) | (32'(m_ovf) << 8);
  endfunction

  function automatic logic [31:0] exp_head();
    if (q_stat.size() == 0) return 32'h0;
    return 32'h8000_0000 | (32'(q_stat.size()) << 16) | 32'(q_stat[0]);
  endfunction

  function automatic logic [31:0] exp_head_ts();
    if (q_ts.size() == 0) return 32'h0;
    return q_ts[0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(2'd0, v); chk({tag, " status"}, v, exp_status());
    rd(2'd1, v); chk({tag, " last_ts"}, v, m_last);
    rd(2'd2, v); chk({tag, " head"}, v, exp_head());
    rd(2'd3, v); chk({tag, " head_ts"}, v, exp_head_ts());
  endtask

  task automatic model_event(input logic [1:0] nl, input logic [31:0] ts);
    logic [1:0] mask;
    mask = nl ^ m_lvl;
    m_lvl = nl;
    if (mask != 2'b00) begin
      m_pend |= mask;
      m_last = ts;
      if (buf_mode) begin
        if (q_stat.size() < 4) begin
          q_stat.push_back(8'((32'(mask) << 1) | (32'(nl) << 5)));
          q_ts.push_back(ts);
        end else m_ovf = 1'b1;
      end
    end
  endtask

  // Input change at N0; edge detected before edge k+2; sample ts at N2
  task automatic set_trig(input logic [1:0] nl);
    logic [31:0] ts;
    @(negedge clk); trig = nl;
    @(negedge clk);
    @(negedge clk); ts = ts_now;
    @(negedge clk);
    model_event(nl, ts);
  endtask

  task automatic clear_w(input logic [31:0] d);
    wr_reg(2'd0, d);
    m_pend &= ~d[2:1];
    if (d[8]) m_ovf = 1'b0;
  endtask

  task automatic pop_q();
    wr_reg(2'd2, 32'h0);
    if (q_stat.size() != 0) begin
      void'(q_stat.pop_front());
      void'(q_ts.pop_front());
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t0;
    void'($urandom(32'd24681357));
    rst_n = 1'b0; trig = 2'b00; buf_mode = 1'b0;
    addr = 2'd0; wr = 1'b0; wdata = 32'h0;
    m_lvl = 2'b00; m_pend = 2'b00; m_ovf = 1'b0; m_last = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_all("R1");

    // R6: timestamp steps once per cycle
    @(negedge clk); t0 = ts_now;
    repeat (7) @(negedge clk);
    chk("R6 ts step", ts_now - t0, 32'd7);

    // R2/R3/R7/R9: raw mode, rising then falling edge on trigger 0
    set_trig(2'b01); check_all("R2 R3 R7 R9 rise");
    clear_w(32'h2);  check_all("R4 clear bit1");
    set_trig(2'b00); check_all("R3 R9 fall");
    set_trig(2'b10); check_all("R2 R3 trig1");
    clear_w(32'h4);  check_all("R4 clear bit2 only");

    // R5: writes to read-only status bits have no effect
    clear_w(32'hFFFF_FE79); check_all("R5 ro bits");
    // R11: writes to addresses 1 and 3 ignored
    wr_reg(2'd1, 32'hDEAD_BEEF); wr_reg(2'd3, 32'h1234_5678);
    check_all("R11 ignored writes");

    // R8: buffered mode, simultaneous edges give one record
    @(negedge clk); buf_mode = 1'b1;
    set_trig(2'b01);
    check_all("R8 single record");
    pop_q(); pop_q(); check_all("R8 pop empty");

    // R10: overflow after four records
    set_trig(2'b10);   // both change: one record
    check_all("R8 simultaneous");
    set_trig(2'b11); set_trig(2'b00); set_trig(2'b01);
    check_all("R8 full");
    set_trig(2'b11);
    check_all("R10 overflow");
    pop_q(); check_all("R10 kept order");
    clear_w(32'h100); check_all("R10 ovf clear");
    repeat (4) pop_q();
    check_all("R8 drained");

    // R4: clear and event in the same cycle, event wins
    @(negedge clk); buf_mode = 1'b0;
    set_trig(2'b00);
    begin
      logic [31:0] ts;
      @(negedge clk); trig = 2'b01;
      @(negedge clk);
      @(negedge clk); ts = ts_now; addr = 2'd0; wdata = 32'h2; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      m_pend[0] = 1'b0;
      model_event(2'b01, ts);
    end
    check_all("R4 event beats clear");

    // Random mix
    for (int n = 0; n < 250; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5)       set_trig(2'($urandom_range(0, 3)));
      else if (op < 7)  clear_w($urandom);
      else if (op < 9)  pop_q();
      else begin @(negedge clk); buf_mode = ~buf_mode; end
      check_all("R3 R4 R8 R9 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule